// File: doc/BRIEF.md
# Endpoint FIFO Address Mapper

This block turns endpoint FIFO accesses into physical addresses inside one 4 KB packet RAM that every endpoint shares. Endpoint 0 owns a fixed 64-byte region at the bottom of the RAM. Endpoints 1 to 4 each carry two independent settings, one for transmit and one for receive. Each setting holds a start address, a maximum packet size and a double-buffer enable.

Firmware programs the settings through a small register window. An index register picks the endpoint, and the window registers then read and write that endpoint's transmit and receive settings. The access side takes an endpoint number, a direction, a byte offset and a buffer select. One clock later it returns a RAM address with an enable strobe. An access that would leave the endpoint's allocation, or the RAM, raises an error flag instead of the enable.

Top module: `epfifo_mapper`

## Requirements
- R1: After reset, the index register is 0, every endpoint 1..4 setting is cleared (start 0, size code 0, double buffering off), and `ram_en`, `acc_err` and `ram_addr` are 0.
- R2: Register select `cfg_addr` is decoded as follows:
  - 0 is the index register, bits [3:0].
  - 1 is the transmit start, bits [8:0], in 8-byte units.
  - 2 is the transmit sizing: bits [2:0] hold code c for a packet size of 8<<c bytes, and bit 4 enables double buffering.
  - 3 and 4 are the receive start and receive sizing, laid out like 1 and 2.

  `cfg_rdata` shows the selected register at once, with unused bits 0. Selects 5 to 7 read 0.
- R3: A write to selects 1 to 4 changes only the endpoint held in the index register, and only the addressed direction.
- R4: While the index is 0 or above 4, writes to selects 1 to 4 are ignored. With index 0, reads return start 0 and sizing 3 (64 bytes, single buffer). With index above 4, they return 0.
- R5: Endpoint 0 maps offset o to address o, for either direction and either buffer select, and accepts offsets 0 to 63.
- R6: A valid in-range access to endpoint 1 to 4 gives `ram_en`=1 and `ram_addr` = start*8 + offset on the clock edge after the request.
- R7: With double buffering on, buffer select 1 adds one maximum packet size to the address. With it off, buffer select has no effect.
- R8: An offset at or above the endpoint's maximum packet size gives `acc_err`=1, `ram_en`=0 and `ram_addr`=0; `ram_en` and `acc_err` are never both 1.
- R9: An access whose computed address is 4096 or more is flagged as in R8.
- R10: An endpoint number from 5 to 7 is always flagged as in R8.
- R11: A clock edge with `acc_valid`=0 leaves `ram_en`, `acc_err` and `ram_addr` at 0 in the next cycle.
- R12: Direction `acc_dir`=1 (transmit) uses the transmit settings and 0 (receive) uses the receive settings of the same endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| acc_valid | input | 1 | Access request valid |
| acc_ep | input | 3 | Endpoint number |
| acc_dir | input | 1 | 1 = transmit, 0 = receive |
| acc_off | input | 11 | Byte offset within the packet |
| acc_buf | input | 1 | Buffer select for double buffering |
| ram_en | output | 1 | Registered RAM enable |
| ram_addr | output | 12 | Registered RAM byte address |
| acc_err | output | 1 | Registered out-of-allocation flag |

## Verification
The assertions check on every cycle the rules that hold regardless of configuration:
- the enable and the error flag never rise together;
- idle cycles stay quiet;
- endpoint 0 passes its offset straight through;
- bad endpoint numbers and offsets of 1024 or more are flagged;
- reads above the last endpoint return zero;
- the index register moves only when written.

Address arithmetic depends on the programmed starts, sizes and buffer flags. So do the 4096 boundary, the independence between endpoints and directions, and the ignored writes at index 0. Only the bench's scenarios, compared cycle by cycle against its reference model, can show these.

// File: rtl/epfifo_pkg.sv
package epfifo_pkg;
    localparam int RAM_BYTES  = 4096;
    localparam int UNIT_BYTES = 8;
    localparam int EP0_BYTES  = 64;
    localparam int MIN_PKT    = 8;
    localparam int MAX_PKT    = 1024;
    localparam int NUM_CFG_EP = 4;

    localparam int ADDR_W  = $clog2(RAM_BYTES);
    localparam int START_W = $clog2(RAM_BYTES / UNIT_BYTES);
    localparam int UNIT_SH = $clog2(UNIT_BYTES);
    localparam int MIN_SH  = $clog2(MIN_PKT);
    localparam int CODE_W  = $clog2($clog2(MAX_PKT) - MIN_SH + 1);
    localparam int EP0_CODE = $clog2(EP0_BYTES) - MIN_SH;
    localparam int OFF_W   = ADDR_W - 1;
    localparam int SIZE_W  = $clog2(MAX_PKT) + 1;
    localparam int SUM_W   = ADDR_W + 2;
    localparam int EP_W    = 3;
    localparam int IDX_W   = 4;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = 3;
    localparam int DBL_BIT = 4;

    typedef enum logic [SEL_W-1:0] {
        REG_INDEX    = 3'd0,
        REG_TX_START = 3'd1,
        REG_TX_SIZE  = 3'd2,
        REG_RX_START = 3'd3,
        REG_RX_SIZE  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic [CODE_W-1:0]  code;
        logic               dbl;
    } dir_cfg_t;

    typedef struct packed {
        dir_cfg_t tx;
        dir_cfg_t rx;
    } ep_cfg_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } ram_req_t;
endpackage

// File: rtl/epfifo_ep_slot.sv
module epfifo_ep_slot
    import epfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output ep_cfg_t           cfg_o
);
    ep_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && sel) begin
            case (reg_sel_e'(reg_sel))
                REG_TX_START: cfg_d.tx.start = wdata[START_W-1:0];
                REG_TX_SIZE: begin
                    cfg_d.tx.code = wdata[CODE_W-1:0];
                    cfg_d.tx.dbl  = wdata[DBL_BIT];
                end
                REG_RX_START: cfg_d.rx.start = wdata[START_W-1:0];
                REG_RX_SIZE: begin
                    cfg_d.rx.code = wdata[CODE_W-1:0];
                    cfg_d.rx.dbl  = wdata[DBL_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/epfifo_cfg_bank.sv
module epfifo_cfg_bank
    import epfifo_pkg::*;
#(
    parameter int NUM_EP = NUM_CFG_EP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SEL_W-1:0]       reg_sel,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic [IDX_W-1:0]       idx_o,
    output ep_cfg_t [NUM_EP:1]     cfg_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } bank_st_t;

    bank_st_t st_d, st_q;
    ep_cfg_t  [NUM_EP:1] slot_cfg;
    ep_cfg_t  view;
    logic     view_hit;

    always_comb begin
        st_d = st_q;
        if (we && reg_sel == REG_INDEX) st_d.idx = wdata[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 1; g <= NUM_EP; g++) begin : g_slot
        epfifo_ep_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (st_q.idx == IDX_W'(g)),
            .we      (we),
            .reg_sel (reg_sel),
            .wdata   (wdata),
            .cfg_o   (slot_cfg[g])
        );
    end

    // Pick the settings visible through the window
    always_comb begin
        view     = '0;
        view_hit = 1'b0;
        if (st_q.idx == '0) begin
            view.tx.code = CODE_W'(EP0_CODE);
            view.rx.code = CODE_W'(EP0_CODE);
            view_hit     = 1'b1;
        end
        for (int k = 1; k <= NUM_EP; k++) begin
            if (st_q.idx == IDX_W'(k)) begin
                view     = slot_cfg[k];
                view_hit = 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(reg_sel))
            REG_INDEX:    rdata = DATA_W'(st_q.idx);
            REG_TX_START: if (view_hit) rdata = DATA_W'(view.tx.start);
            REG_TX_SIZE:  if (view_hit) rdata = DATA_W'({view.tx.dbl, 1'b0, view.tx.code});
            REG_RX_START: if (view_hit) rdata = DATA_W'(view.rx.start);
            REG_RX_SIZE:  if (view_hit) rdata = DATA_W'({view.rx.dbl, 1'b0, view.rx.code});
            default:      rdata = '0;
        endcase
    end

    assign idx_o = st_q.idx;
    assign cfg_o = slot_cfg;
endmodule

// File: rtl/epfifo_addr_calc.sv
module epfifo_addr_calc
    import epfifo_pkg::*;
#(
    parameter int NUM_EP = NUM_CFG_EP
) (
    input  ep_cfg_t [NUM_EP:1]  cfg_i,
    input  logic                valid,
    input  logic [EP_W-1:0]     ep,
    input  logic                dir,
    input  logic [OFF_W-1:0]    off,
    input  logic                bsel,
    output ram_req_t            req
);
    ep_cfg_t           ep_cfg;
    dir_cfg_t          dcfg;
    logic              ep_ok;
    logic [SIZE_W-1:0] size;
    logic [SUM_W-1:0]  base;
    logic [SUM_W-1:0]  sum;
    logic              bad;

    always_comb begin
        ep_cfg = '0;
        ep_ok  = (ep == '0);
        for (int k = 1; k <= NUM_EP; k++) begin
            if (ep == EP_W'(k)) begin
                ep_cfg = cfg_i[k];
                ep_ok  = 1'b1;
            end
        end
        dcfg = dir ? ep_cfg.tx : ep_cfg.rx;
        if (ep == '0) begin
            dcfg       = '0;
            dcfg.code  = CODE_W'(EP0_CODE);
        end
    end

    always_comb begin
        size = SIZE_W'(1) << (SIZE_W'(dcfg.code) + SIZE_W'(MIN_SH));
        base = SUM_W'(dcfg.start) << UNIT_SH;
        sum  = base + SUM_W'(off);
        if (bsel && dcfg.dbl) sum = sum + SUM_W'(size);
        bad  = !ep_ok
            || (SIZE_W'(off) >= size)
            || (sum >= SUM_W'(RAM_BYTES));
    end

    always_comb begin
        req = '0;
        if (valid) begin
            req.err = bad;
            req.en  = !bad;
            if (!bad) req.addr = sum[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/epfifo_mapper.sv
module epfifo_mapper
    import epfifo_pkg::*;
#(
    parameter int NUM_EP = NUM_CFG_EP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              acc_valid,
    input  logic [EP_W-1:0]   acc_ep,
    input  logic              acc_dir,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic              acc_buf,
    output logic              ram_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              acc_err
);
    ep_cfg_t [NUM_EP:1] cfg_all;
    logic [IDX_W-1:0]   cur_idx;
    ram_req_t           req_d, req_q;

    epfifo_cfg_bank #(.NUM_EP(NUM_EP)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .reg_sel (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .idx_o   (cur_idx),
        .cfg_o   (cfg_all)
    );

    epfifo_addr_calc #(.NUM_EP(NUM_EP)) u_calc (
        .cfg_i (cfg_all),
        .valid (acc_valid),
        .ep    (acc_ep),
        .dir   (acc_dir),
        .off   (acc_off),
        .bsel  (acc_buf),
        .req   (req_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign ram_en   = req_q.en;
    assign ram_addr = req_q.addr;
    assign acc_err  = req_q.err;
endmodule

// File: rtl/epfifo_mapper_chk.sv
module epfifo_mapper_chk
    import epfifo_pkg::*;
#(
    parameter int NUM_EP = NUM_CFG_EP
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [SEL_W-1:0]  cfg_addr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [IDX_W-1:0]  cur_idx,
    input logic              acc_valid,
    input logic [EP_W-1:0]   acc_ep,
    input logic [OFF_W-1:0]  acc_off,
    input logic              ram_en,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              acc_err
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ram_en && !acc_err)); // R1

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == SEL_W'(0)) |=> $stable(cur_idx)); // R2

    AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != '0 && cur_idx > IDX_W'(NUM_EP)) |-> cfg_rdata == '0); // R4

    AST_EP0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ep == '0 && acc_off < OFF_W'(EP0_BYTES))
        |=> (ram_en && ram_addr == ADDR_W'($past(acc_off)))); // R5

    AST_EN_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_en && acc_err)); // R8

    AST_BIG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_off >= OFF_W'(MAX_PKT)) |=> acc_err); // R8

    AST_BAD_EP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ep > EP_W'(NUM_EP)) |=> (acc_err && !ram_en)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!ram_en && !acc_err && ram_addr == '0)); // R11
endmodule

bind epfifo_mapper epfifo_mapper_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .cur_idx   (cur_idx),
    .acc_valid (acc_valid),
    .acc_ep    (acc_ep),
    .acc_off   (acc_off),
    .ram_en    (ram_en),
    .ram_addr  (ram_addr),
    .acc_err   (acc_err)
);

// File: tb/epfifo_mapper_tb_top.sv
module epfifo_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_ep = '0;
    logic        acc_dir = 1'b0;
    logic [10:0] acc_off = '0;
    logic        acc_buf = 1'b0;
    logic        ram_en;
    logic [11:0] ram_addr;
    logic        acc_err;

    int n_chk = 0;
    int n_fail = 0;
    bit model_on = 1'b0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    epfifo_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_ep(acc_ep), .acc_dir(acc_dir), .acc_off(acc_off), .acc_buf(acc_buf),
        .ram_en(ram_en), .ram_addr(ram_addr), .acc_err(acc_err)
    );

    // Behavioural reference model: per-endpoint, per-direction settings
    int m_start [5][2];
    int m_code  [5][2];
    int m_dbl   [5][2];
    int m_idx;
    int e_en, e_addr, e_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < 5; e++)
                for (int d = 0; d < 2; d++) begin
                    m_start[e][d] = 0; m_code[e][d] = 0; m_dbl[e][d] = 0;
                end
            m_idx = 0; e_en = 0; e_addr = 0; e_err = 0;
        end else begin
            int base, size, dbl, phys, bad;
            e_en = 0; e_addr = 0; e_err = 0;
            if (acc_valid) begin
                bad = 0; base = 0; size = 64; dbl = 0;
                if (acc_ep > 4) bad = 1;
                else if (acc_ep != 0) begin
                    base = m_start[acc_ep][acc_dir] * 8;
                    size = 8 << m_code[acc_ep][acc_dir];
                    dbl  = m_dbl[acc_ep][acc_dir];
                end
                phys = base + int'(acc_off) + ((acc_buf && dbl != 0) ? size : 0);
                if (int'(acc_off) >= size || phys >= 4096) bad = 1;
                if (bad != 0) e_err = 1;
                else begin e_en = 1; e_addr = phys; end
            end
            if (cfg_we) begin
                if (cfg_addr == 0) m_idx = int'(cfg_wdata[3:0]);
                else if (m_idx >= 1 && m_idx <= 4 && cfg_addr <= 4) begin
                    int d;
                    d = (cfg_addr <= 2) ? 1 : 0;
                    if (cfg_addr == 1 || cfg_addr == 3) m_start[m_idx][d] = int'(cfg_wdata[8:0]);
                    else begin
                        m_code[m_idx][d] = int'(cfg_wdata[2:0]);
                        m_dbl[m_idx][d]  = int'(cfg_wdata[4]);
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            n_chk++;
            if (int'(ram_en) != e_en || int'(ram_addr) != e_addr || int'(acc_err) != e_err) begin
                n_fail++;
                $display("FAIL %s model: en/addr/err=%0d/%0d/%0d expected %0d/%0d/%0d",
                         cur_tag, ram_en, ram_addr, acc_err, e_en, e_addr, e_err);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        cfg_addr = 3'(a);
        #1;
        chk(tag, int'(cfg_rdata), exp);
    endtask

    task automatic acc(input int ep, input int dir, input int off, input int b,
                       input int x_en, input int x_addr, input int x_err, input string tag);
        cur_tag = tag;
        acc_valid = 1'b1; acc_ep = 3'(ep); acc_dir = dir[0]; acc_off = 11'(off); acc_buf = b[0];
        @(negedge clk);
        acc_valid = 1'b0;
        chk({tag, " en"}, int'(ram_en), x_en);
        chk({tag, " addr"}, int'(ram_addr), x_addr);
        chk({tag, " err"}, int'(acc_err), x_err);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        model_on = 1'b1;
        chk("R1 en", int'(ram_en), 0);
        chk("R1 err", int'(acc_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, 0, "R1 index");
        wr(0, 1);
        rd(1, 0, "R1 start");
        rd(2, 0, "R1 sizing");

        // R2: program endpoint 1 and read it back
        cur_tag = "R2";
        wr(1, 16); wr(2, 16'h0014); wr(3, 100); wr(4, 2);
        rd(0, 1, "R2 index");
        rd(1, 16, "R2 tx start");
        rd(2, 16'h0014, "R2 tx sizing");
        rd(3, 100, "R2 rx start");
        rd(4, 2, "R2 rx sizing");
        rd(5, 0, "R2 unused select");
        wr(1, 16'hFE10);
        rd(1, 16, "R2 start upper bits dropped");
        wr(1, 16);

        // R3: other endpoints untouched
        cur_tag = "R3";
        wr(0, 2); wr(1, 200); wr(2, 7);
        rd(3, 0, "R3 ep2 rx untouched");
        wr(0, 3); wr(1, 511); wr(2, 3); wr(3, 400); wr(4, 16'h0017);
        wr(0, 1);
        rd(1, 16, "R3 ep1 tx kept");
        rd(4, 2, "R3 ep1 rx kept");

        // R4: index 0 and out-of-range index
        cur_tag = "R4";
        wr(0, 0); wr(1, 55); wr(2, 16'h0017); wr(3, 9);
        rd(1, 0, "R4 ep0 start");
        rd(2, 3, "R4 ep0 sizing");
        rd(4, 3, "R4 ep0 rx sizing");
        wr(0, 6); wr(1, 77); wr(2, 5);
        rd(1, 0, "R4 high index start");
        rd(2, 0, "R4 high index sizing");
        rd(0, 6, "R4 high index readback");
        wr(0, 1);
        rd(1, 16, "R4 ep1 unchanged");

        // Accesses
        acc(0, 0, 10, 1, 1, 10, 0, "R5 ep0 off10");
        acc(0, 1, 63, 0, 1, 63, 0, "R5 ep0 off63");
        acc(0, 1, 64, 0, 0, 0, 1, "R8 ep0 off64");
        acc(1, 1, 5, 0, 1, 133, 0, "R6 ep1 tx");
        acc(1, 1, 5, 1, 1, 261, 0, "R7 ep1 tx buf1");
        acc(1, 0, 5, 1, 1, 805, 0, "R7 ep1 rx buf ignored");
        acc(1, 0, 31, 0, 1, 831, 0, "R12 ep1 rx last byte");
        acc(1, 0, 32, 0, 0, 0, 1, "R12 ep1 rx size limit");
        acc(1, 1, 127, 1, 1, 383, 0, "R7 ep1 tx last byte buf1");
        acc(1, 1, 128, 0, 0, 0, 1, "R8 ep1 tx off128");
        acc(2, 1, 1023, 0, 1, 2623, 0, "R6 ep2 tx 1024");
        acc(2, 0, 8, 0, 0, 0, 1, "R12 ep2 rx default 8");
        acc(3, 1, 7, 0, 1, 4095, 0, "R9 ep3 top byte");
        acc(3, 1, 8, 0, 0, 0, 1, "R9 ep3 past top");
        acc(3, 0, 895, 0, 1, 4095, 0, "R9 ep3 rx top byte");
        acc(3, 0, 0, 1, 0, 0, 1, "R9 ep3 rx second buffer");
        acc(4, 1, 3, 0, 1, 3, 0, "R6 ep4 default");
        acc(5, 1, 0, 0, 0, 0, 1, "R10 ep5");
        acc(7, 0, 0, 0, 0, 0, 1, "R10 ep7");
        acc(2, 1, 1500, 0, 0, 0, 1, "R8 large offset");

        cur_tag = "R11";
        acc_ep = 3'd1; acc_off = 11'd5;
        repeat (2) @(negedge clk);
        chk("R11 idle en", int'(ram_en), 0);
        chk("R11 idle addr", int'(ram_addr), 0);

        // Mixed traffic against the model
        cur_tag = "R6";
        for (int i = 0; i < 600; i++) begin
            cfg_we    = ($urandom_range(0, 3) == 0);
            cfg_addr  = 3'($urandom_range(0, 5));
            cfg_wdata = (cfg_addr == 0) ? 16'($urandom_range(0, 6)) : 16'($urandom);
            acc_valid = ($urandom_range(0, 3) != 0);
            acc_ep    = 3'($urandom_range(0, 6));
            acc_dir   = 1'($urandom_range(0, 1));
            acc_off   = 11'($urandom_range(0, 1100));
            acc_buf   = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        cfg_we = 1'b0; acc_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule